// File: doc/BRIEF.md
# Motor Driver Fault and Sleep Supervisor

This block decides when each half of a dual-bridge motor driver may switch. It takes digital indications from the analog detectors: supply undervoltage, die over-temperature, and one current-limit flag per bridge. It also takes the active-low sleep request. From these it produces a per-bridge disable, an active-low fault flag, an enable for the internal regulator, a global reset for the rest of the driver logic, and a one-cycle wake strobe. The input decoder uses that strobe to re-latch its operating mode.

Current-limit events are filtered and retried separately for each bridge, so a short on one winding never stops the other. Over-temperature stops both bridges only for as long as the condition lasts. Undervoltage shuts the whole driver down and clears every counter and state in the supervisor. When the supply recovers, the driver powers up again through the normal wake delay. The fault flag is never latched, and every time window is a counter whose limit is a parameter.

Top module: `mdrv_supervisor`

## Requirements
- R1: When `ilim_i[b]` is sampled high on OCP_DGL_CYC consecutive clock edges, bridge b is disabled and `fault_n_o` goes low, both in the cycle after the last of those edges.
- R2: If `ilim_i[b]` is sampled low before the run of high samples is complete, the run count returns to zero and no fault is raised. A later run must again be full length.
- R3: After an overcurrent trip, bridge b stays disabled for exactly OCP_RETRY_CYC cycles and is then driven again. A further trip needs a new full run of high samples.
- R4: An overcurrent trip on one bridge leaves the disable output of every other bridge unchanged.
- R5: One cycle after `ot_i` is sampled high, all bridges are disabled and `fault_n_o` is low. One cycle after `ot_i` is sampled low, both are released, provided no other fault is active.
- R6: One cycle after `uv_i` is sampled high, `logic_rst_o` is high, `reg_en_o` is low, all bridges are disabled and `fault_n_o` is low. On the following edge every overcurrent and sleep/wake state is cleared, so recovery goes through the wake delay of R8.
- R7: After `sleep_n_i` is first sampled low while active, the bridge outputs keep their state for SLEEP_DLY_CYC cycles. After that, all bridges are disabled and `reg_en_o` goes low. If `sleep_n_i` is sampled high during that window, the sleep request is abandoned.
- R8: When `sleep_n_i` is sampled high while asleep, `reg_en_o` rises one cycle later. The bridges stay disabled for WAKE_DLY_CYC cycles and are then enabled. If `sleep_n_i` is sampled low during the wake window, the block returns to sleep. The regulator is never off while a bridge is enabled.
- R9: `wake_stb_o` is high for exactly one cycle: the first cycle in which the bridges are enabled after a wake.
- R10: `fault_n_o` is low exactly when undervoltage, over-temperature or an overcurrent trip is currently active. Sleep is not a fault.
- R11: While `rst_n` is low, and after it is released, the block starts asleep: all bridges disabled, `reg_en_o` low, `fault_n_o` high, `logic_rst_o` low and `wake_stb_o` low. With `sleep_n_i` high, it then follows the wake sequence of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_i | input | 1 | Supply undervoltage, active high |
| ot_i | input | 1 | Over-temperature, active high |
| ilim_i | input | NUM_BRIDGE | Per-bridge current-limit indication, active high |
| sleep_n_i | input | 1 | Sleep request, active low |
| bridge_off_o | output | NUM_BRIDGE | Per-bridge switch disable, high = all switches off |
| fault_n_o | output | 1 | Fault flag, low while any fault is active |
| reg_en_o | output | 1 | Internal regulator enable |
| logic_rst_o | output | 1 | Global reset for the driver's other logic |
| wake_stb_o | output | 1 | One-cycle strobe at the end of the wake delay |

## Verification
Every output comes from a register, so each result appears one cycle after the edge that samples its cause:
- Temperature and undervoltage take effect one cycle after they are sampled.
- An overcurrent trip shows one cycle after the OCP_DGL_CYC-th high sample.
- A release after a trip comes OCP_RETRY_CYC cycles after the trip.
- Sleep takes effect SLEEP_DLY_CYC cycles after the first low sample of `sleep_n_i`.
- Bridges are enabled WAKE_DLY_CYC cycles after the first high sample while asleep.

The bench advances a behavioural model at each rising edge from the inputs it drove at the previous falling edge. It then compares every output against that model at the next falling edge, so each expectation is checked in exactly the cycle it is due.

// File: rtl/mdrv_sup_pkg.sv
package mdrv_sup_pkg;

  // Power sequencing states
  typedef enum logic [1:0] {
    PS_ACTIVE     = 2'd0,
    PS_SLEEP_WAIT = 2'd1,
    PS_ASLEEP     = 2'd2,
    PS_WAKE_WAIT  = 2'd3
  } pwr_state_e;

  // Per-bridge overcurrent states
  typedef enum logic {
    OC_WATCH = 1'b0,
    OC_HOLD  = 1'b1
  } oc_state_e;

endpackage

// File: rtl/mdrv_ocp_chan.sv
module mdrv_ocp_chan
  import mdrv_sup_pkg::*;
#(
  parameter int unsigned DGL_CYC   = 8,
  parameter int unsigned RETRY_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic ilim_i,
  output logic trip_o
);

  localparam int unsigned MAXC = (DGL_CYC > RETRY_CYC) ? DGL_CYC : RETRY_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DGL_LAST   = CW'(DGL_CYC - 1);
  localparam logic [CW-1:0] RETRY_LAST = CW'(RETRY_CYC - 1);

  oc_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd_en;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      st_d  = OC_WATCH;
      cnt_d = '0;
    end else if (st_q == OC_WATCH) begin
      if (!ilim_i) begin
        cnt_d = '0;
      end else if (cnt_q == DGL_LAST) begin
        st_d  = OC_HOLD;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == RETRY_LAST) begin
        st_d  = OC_WATCH;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign upd_en = (st_d != st_q) || (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= OC_WATCH;
      cnt_q <= '0;
    end else if (upd_en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign trip_o = (st_q == OC_HOLD);

  // R1: a trip is always preceded by a high current-limit sample
  a_r1_trip_needs_ilim: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_o) |-> $past(ilim_i));

  // R2: a low sample while watching never leads to a trip
  a_r2_low_blocks_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip_o && !ilim_i) |=> !trip_o);

  // R3: the retry count stays inside its window
  a_r3_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o |-> (cnt_q <= RETRY_LAST));

endmodule

// File: rtl/mdrv_pwr_seq.sv
module mdrv_pwr_seq
  import mdrv_sup_pkg::*;
#(
  parameter int unsigned SLEEP_CYC = 16,
  parameter int unsigned WAKE_CYC  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic sleep_n_i,
  output logic drive_en_o,
  output logic reg_on_o,
  output logic wake_stb_o
);

  localparam int unsigned MAXC = (SLEEP_CYC > WAKE_CYC) ? SLEEP_CYC : WAKE_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SLEEP_LAST = CW'(SLEEP_CYC - 1);
  localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_CYC - 1);

  pwr_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          stb_q, stb_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    stb_d = 1'b0;
    if (clr_i) begin
      st_d  = PS_ASLEEP;
      cnt_d = '0;
    end else begin
      case (st_q)
        PS_ACTIVE: begin
          if (!sleep_n_i) begin
            st_d  = PS_SLEEP_WAIT;
            cnt_d = '0;
          end
        end
        PS_SLEEP_WAIT: begin
          if (sleep_n_i) begin
            st_d  = PS_ACTIVE;
            cnt_d = '0;
          end else if (cnt_q == SLEEP_LAST) begin
            st_d  = PS_ASLEEP;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PS_ASLEEP: begin
          if (sleep_n_i) begin
            st_d  = PS_WAKE_WAIT;
            cnt_d = '0;
          end
        end
        default: begin
          if (!sleep_n_i) begin
            st_d  = PS_ASLEEP;
            cnt_d = '0;
          end else if (cnt_q == WAKE_LAST) begin
            st_d  = PS_ACTIVE;
            cnt_d = '0;
            stb_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_ASLEEP;
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      stb_q <= stb_d;
    end
  end

  assign drive_en_o = (st_q == PS_ACTIVE) || (st_q == PS_SLEEP_WAIT);
  assign reg_on_o   = (st_q != PS_ASLEEP);
  assign wake_stb_o = stb_q;

  // R9: the strobe lasts a single cycle
  a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake_stb_o |=> !wake_stb_o);

  // R9: the strobe only follows a sustained wake request
  a_r9_strobe_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    wake_stb_o |-> ($past(sleep_n_i) && drive_en_o));

  // R8: driving only starts once the regulator was already on
  a_r8_reg_before_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en_o) |-> $past(reg_on_o));

endmodule

// File: rtl/mdrv_supervisor.sv
module mdrv_supervisor
  import mdrv_sup_pkg::*;
#(
  parameter int unsigned NUM_BRIDGE    = 2,
  parameter int unsigned OCP_DGL_CYC   = 8,
  parameter int unsigned OCP_RETRY_CYC = 64,
  parameter int unsigned SLEEP_DLY_CYC = 16,
  parameter int unsigned WAKE_DLY_CYC  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  uv_i,
  input  logic                  ot_i,
  input  logic [NUM_BRIDGE-1:0] ilim_i,
  input  logic                  sleep_n_i,
  output logic [NUM_BRIDGE-1:0] bridge_off_o,
  output logic                  fault_n_o,
  output logic                  reg_en_o,
  output logic                  logic_rst_o,
  output logic                  wake_stb_o
);

  logic                  uv_q, ot_q;
  logic [NUM_BRIDGE-1:0] trip;
  logic                  drive_en, reg_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_q <= 1'b0;
      ot_q <= 1'b0;
    end else begin
      uv_q <= uv_i;
      ot_q <= ot_i;
    end
  end

  for (genvar b = 0; b < NUM_BRIDGE; b++) begin : g_bridge
    mdrv_ocp_chan #(
      .DGL_CYC   (OCP_DGL_CYC),
      .RETRY_CYC (OCP_RETRY_CYC)
    ) u_ocp (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (uv_q),
      .ilim_i (ilim_i[b]),
      .trip_o (trip[b])
    );
  end

  mdrv_pwr_seq #(
    .SLEEP_CYC (SLEEP_DLY_CYC),
    .WAKE_CYC  (WAKE_DLY_CYC)
  ) u_pwr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (uv_q),
    .sleep_n_i  (sleep_n_i),
    .drive_en_o (drive_en),
    .reg_on_o   (reg_on),
    .wake_stb_o (wake_stb_o)
  );

  always_comb begin
    for (int b = 0; b < NUM_BRIDGE; b++) begin
      bridge_off_o[b] = uv_q | ot_q | trip[b] | ~drive_en;
    end
  end

  assign fault_n_o   = ~(uv_q | ot_q | (|trip));
  assign reg_en_o    = reg_on & ~uv_q;
  assign logic_rst_o = uv_q;

  // R5: over-temperature stops every bridge and flags a fault
  a_r5_thermal_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && ot_i) |-> (&bridge_off_o && !fault_n_o));

  // R6: undervoltage shuts everything down
  a_r6_uv_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && uv_i) |-> (logic_rst_o && !reg_en_o && &bridge_off_o && !fault_n_o));

  // R10: the flag is released as soon as no fault source remains
  a_r10_flag_unlatched: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && !uv_i && !ot_i) && (trip == '0)) |-> fault_n_o);

  // R8: no bridge is driven while the regulator is off
  a_r8_no_drive_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en_o |-> &bridge_off_o);

endmodule

// File: tb/mdrv_supervisor_tb.sv
module mdrv_supervisor_tb_top;

  localparam int NB  = 2;
  localparam int DGL = 4;
  localparam int RET = 12;
  localparam int SD  = 6;
  localparam int WD  = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          uv_i, ot_i, sleep_n_i;
  logic [NB-1:0] ilim_i;
  logic [NB-1:0] bridge_off_o;
  logic          fault_n_o, reg_en_o, logic_rst_o, wake_stb_o;

  always #10 clk = ~clk;

  mdrv_supervisor #(
    .NUM_BRIDGE    (NB),
    .OCP_DGL_CYC   (DGL),
    .OCP_RETRY_CYC (RET),
    .SLEEP_DLY_CYC (SD),
    .WAKE_DLY_CYC  (WD)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .uv_i         (uv_i),
    .ot_i         (ot_i),
    .ilim_i       (ilim_i),
    .sleep_n_i    (sleep_n_i),
    .bridge_off_o (bridge_off_o),
    .fault_n_o    (fault_n_o),
    .reg_en_o     (reg_en_o),
    .logic_rst_o  (logic_rst_o),
    .wake_stb_o   (wake_stb_o)
  );

  int    nchk = 0;
  int    nerr = 0;
  int    ncyc = 0;
  string cur_req = "R11";

  // Behavioural reference: power mode 0 run, 1 going to sleep, 2 asleep, 3 waking
  int m_mode, m_cnt, m_stb, m_uv, m_ot;
  int m_trip [NB];
  int m_ocnt [NB];

  task automatic chk(input string sig, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d at cycle %0d", cur_req, sig, act, exp, ncyc);
    end
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 2; m_cnt = 0; m_stb = 0; m_uv = 0; m_ot = 0;
      for (int b = 0; b < NB; b++) begin m_trip[b] = 0; m_ocnt[b] = 0; end
    end else begin
      ncyc++;
      m_stb = 0;
      if (m_uv != 0) begin
        m_mode = 2; m_cnt = 0;
        for (int b = 0; b < NB; b++) begin m_trip[b] = 0; m_ocnt[b] = 0; end
      end else begin
        if (m_mode == 0) begin
          if (!sleep_n_i) begin m_mode = 1; m_cnt = 0; end
        end else if (m_mode == 1) begin
          if (sleep_n_i) begin m_mode = 0; m_cnt = 0; end
          else if (m_cnt == SD - 1) begin m_mode = 2; m_cnt = 0; end
          else m_cnt++;
        end else if (m_mode == 2) begin
          if (sleep_n_i) begin m_mode = 3; m_cnt = 0; end
        end else begin
          if (!sleep_n_i) begin m_mode = 2; m_cnt = 0; end
          else if (m_cnt == WD - 1) begin m_mode = 0; m_cnt = 0; m_stb = 1; end
          else m_cnt++;
        end
        for (int b = 0; b < NB; b++) begin
          if (m_trip[b] == 0) begin
            if (!ilim_i[b]) m_ocnt[b] = 0;
            else if (m_ocnt[b] == DGL - 1) begin m_trip[b] = 1; m_ocnt[b] = 0; end
            else m_ocnt[b]++;
          end else begin
            if (m_ocnt[b] == RET - 1) begin m_trip[b] = 0; m_ocnt[b] = 0; end
            else m_ocnt[b]++;
          end
        end
      end
      m_uv = uv_i ? 1 : 0;
      m_ot = ot_i ? 1 : 0;
      if (ncyc > 5000) begin
        nerr++;
        $display("FAIL watchdog: got %0d cycles expected fewer than %0d", ncyc, 5000);
        finish_run();
      end
    end
  end

  // Compare every output in the middle of each cycle
  always @(negedge clk) begin
    int any_trip, drive;
    any_trip = 0;
    for (int b = 0; b < NB; b++) any_trip |= m_trip[b];
    drive = (m_mode == 0 || m_mode == 1) ? 1 : 0;
    for (int b = 0; b < NB; b++)
      chk($sformatf("bridge_off[%0d]", b), int'(bridge_off_o[b]),
          (m_uv | m_ot | m_trip[b] | (drive ^ 1)));
    chk("fault_n", int'(fault_n_o), ((m_uv | m_ot | any_trip) == 0) ? 1 : 0);
    chk("reg_en", int'(reg_en_o), (m_uv == 0 && m_mode != 2) ? 1 : 0);
    chk("logic_rst", int'(logic_rst_o), m_uv);
    chk("wake_stb", int'(wake_stb_o), m_stb);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; uv_i = 1'b0; ot_i = 1'b0; ilim_i = '0; sleep_n_i = 1'b1;
    cyc(3);
    rst_n = 1'b1;
    // R11: reset state, then power-up wake
    cyc(2);
    cur_req = "R8";  cyc(WD - 2);
    cur_req = "R9";  cyc(4);
    // R1 trip, then R3 retry with the limit still present
    cur_req = "R1";  ilim_i[0] = 1'b1; cyc(DGL + 2);
    cur_req = "R3";  cyc(RET + DGL + 2);
    ilim_i[0] = 1'b0; cyc(RET + 2);
    // R2: short pulses never trip
    cur_req = "R2";
    ilim_i[0] = 1'b1; cyc(DGL - 1); ilim_i[0] = 1'b0; cyc(1);
    ilim_i[0] = 1'b1; cyc(DGL - 1); ilim_i[0] = 1'b0; cyc(3);
    // R4: the other bridge trips alone
    cur_req = "R4";  ilim_i[1] = 1'b1; cyc(DGL + 2); ilim_i[1] = 1'b0; cyc(RET + 2);
    // R5: thermal pulse
    cur_req = "R5";  ot_i = 1'b1; cyc(5); ot_i = 1'b0; cyc(3);
    // R6: undervoltage during an overcurrent trip
    cur_req = "R6";  ilim_i[0] = 1'b1; cyc(DGL + 2);
    uv_i = 1'b1; cyc(4); uv_i = 1'b0; ilim_i[0] = 1'b0; cyc(WD + 5);
    // R7: aborted sleep, then real sleep
    cur_req = "R7";  sleep_n_i = 1'b0; cyc(3); sleep_n_i = 1'b1; cyc(3);
    sleep_n_i = 1'b0; cyc(SD + 4);
    // R10: fault while asleep, flag follows the condition only
    cur_req = "R10"; ot_i = 1'b1; cyc(3); ot_i = 1'b0; cyc(3);
    // R8: aborted wake, then full wake
    cur_req = "R8";  sleep_n_i = 1'b1; cyc(2); sleep_n_i = 1'b0; cyc(3);
    sleep_n_i = 1'b1; cyc(WD - 1);
    cur_req = "R9";  cyc(4);
    finish_run();
  end

endmodule